// File: doc/BRIEF.md
# Snoop Hit Write-Back Sequencer

This block sits on the processor side of a shared bus. While another master holds the bus, it accepts external snoop strobes, looks up the snooped line in a small direct-mapped tag and state store, and applies the invalidate flag to the line state. When the snooped line is dirty, it pulls the hit-modified output low. It then waits for the hold request to go away, runs a burst write-back of the line as bus master, and grants hold again only after the write-back has finished.

Lines enter the store through a simple fill port that the processor's own miss handling drives. The data array and all other processor traffic belong to other blocks. Bus control signals use active-low polarity where the shared bus does. A write-back is a four-beat burst that advances on each ready. Snoops are locked out from a dirty hit until the burst has finished.

Top module: `snp_wb_seq`

## Requirements
- R1: After a synchronous active-low reset, hold_ack is 0, hitm_n is 1, snoop_hit is 0, ads_n and burst_n are 1, bus_write is 0, and every line is invalid.
- R2: A snoop strobe (snp_strobe_n low at a clock edge) is accepted only if hold_ack is 1 at that edge and was also 1 at the previous edge, the sequencer is idle, and no earlier snoop is still in lookup. Strobes that fail this test change no output and no line state.
- R3: For an accepted snoop that finds its line in the modified state, hitm_n goes low after the second clock edge following the one that sampled the strobe.
- R4: snp_inv is sampled with the strobe. On any hit, 0 leaves the line shared (present, clean) and 1 makes it invalid. snoop_hit shows 1 for a hit and 0 for a miss, with the same timing as R3.
- R5: While idle or holding a dirty hit, hold_ack follows hold_req with one edge of delay. On a dirty hit, the first edge that samples hold_req low drops hold_ack. hold_ack stays 0 for the rest of the write-back, whatever hold_req does.
- R6: The write-back starts GAP_CYCLES edges after the edge that saw hold_req low (default 1). It begins with one cycle of ads_n low, burst_n low and bus_write high, and wb_line carries the line address (address bits above the line offset).
- R7: From the cycle after ads_n, wb_beat starts at 0 and advances by one at each edge that samples rdy_n low with last_n high. A ready sampled during the ads_n cycle is ignored.
- R8: The write-back ends at the edge that samples rdy_n and last_n both low, and hitm_n returns high after that same edge.
- R9: After the write-back ends, hold_ack stays 0 for two more edges and is then set from hold_req.
- R10: Strobes that arrive between a dirty hit and the end of its write-back are ignored, so a second dirty line snooped in that window stays modified.
- R11: A snoop that misses or hits a clean line leaves hitm_n high and hold_ack unchanged.
- R12: A fill_en pulse writes the line named by fill_addr as modified when fill_dirty is 1, or as exclusive (clean) when it is 0. If the same edge also applies a snoop update to that set, the snoop update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_req | input | 1 | Bus hold request from the system |
| hold_ack | output | 1 | Bus hold grant |
| snp_strobe_n | input | 1 | External snoop strobe, active low |
| snp_addr | input | ADDR_W | Snooped byte address |
| snp_inv | input | 1 | Invalidate flag sampled with the strobe |
| hitm_n | output | 1 | Snoop hit on a modified line, active low |
| snoop_hit | output | 1 | Last accepted snoop found its line present |
| fill_en | input | 1 | Write a line into the tag store |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_dirty | input | 1 | Filled line is modified |
| ads_n | output | 1 | Bus address strobe, active low |
| burst_n | output | 1 | Cacheable burst indicator, active low |
| bus_write | output | 1 | Write (1) or read (0) cycle |
| wb_line | output | ADDR_W-OFF_W | Line address of the write-back |
| wb_beat | output | BEAT_W | Current beat index of the write-back |
| rdy_n | input | 1 | Burst ready, active low |
| last_n | input | 1 | Last beat of burst, active low |

## Verification
On every cycle, the embedded assertions check the handshake invariants: a strobe is accepted only after hold_ack has been high for a full cycle; hitm_n falls exactly three edges after acceptance and rises only after a last-beat ready; no strobe is accepted while hitm_n is low; ads_n always comes with burst_n and bus_write and never while the grant is up; beats hold without ready. Only the bench scenarios can show the effects on line state, because they need a later snoop to bring them out. These are the shared versus invalid outcome of the invalidate flag, the survival of a dirty line that was snooped during a write-back, the ready ignored in the address cycle, and the exact gap before the grant returns.

// File: rtl/snp_wb_pkg.sv
// Shared types for the snoop write-back sequencer.
package snp_wb_pkg;

    // Coherence state of one cached line.
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_t;

    // Phases of the hold handshake and write-back burst.
    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_HIT  = 3'd1,
        SQ_GAP  = 3'd2,
        SQ_ADDR = 3'd3,
        SQ_DATA = 3'd4,
        SQ_DONE = 3'd5
    } seq_st_t;

endpackage

// File: rtl/snp_tag_store.sv
// Direct-mapped tag and coherence-state store, one register set per line.
// Assumes at most one snoop update and one fill per cycle; when both target
// the same set, the snoop update wins and the fill is dropped.
module snp_tag_store
    import snp_wb_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output line_st_t         rd_state,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  line_st_t         upd_state,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  line_st_t         fill_state
);

    logic [TAG_W-1:0] tag_all [SETS];
    line_st_t         st_all  [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [TAG_W-1:0] tag_q;
        line_st_t         st_q;
        logic             upd_hit;
        logic             fill_hit;

        assign upd_hit  = upd_en  && (upd_idx  == IDX_W'(s));
        assign fill_hit = fill_en && (fill_idx == IDX_W'(s));

        // Per-line register: reset invalid, snoop update before fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                st_q  <= LS_INV;
            end else if (upd_hit) begin
                st_q  <= upd_state;
            end else if (fill_hit) begin
                tag_q <= fill_tag;
                st_q  <= fill_state;
            end
        end

        assign tag_all[s] = tag_q;
        assign st_all[s]  = st_q;
    end

    // Read port: combinational select of the addressed set.
    always_comb begin
        rd_tag   = tag_all[rd_idx];
        rd_state = st_all[rd_idx];
    end

endmodule

// File: rtl/snp_lookup.sv
// Snoop admission and two-stage lookup pipeline.
// Stage 1 holds an accepted strobe and reads the tag store; stage 2 holds
// the result, which the controller consumes. Assumes seq_idle is low from
// a dirty hit until its write-back finishes.
module snp_lookup
    import snp_wb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_strobe_n,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_inv,
    input  logic              hold_ack,
    input  logic              seq_idle,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  line_st_t          rd_state,
    output logic              accept,
    output logic              upd_en,
    output logic [IDX_W-1:0]  upd_idx,
    output line_st_t          upd_state,
    output logic              res_v,
    output logic              res_mod,
    output logic [LINE_W-1:0] res_line,
    output logic              snoop_hit
);

    logic              ack_d;
    logic              s1_v;
    logic [ADDR_W-1:0] s1_addr;
    logic              s1_inv;
    logic [TAG_W-1:0]  s1_tag;
    logic              look_hit;
    logic              res_hit;

    // Grant history: hold_ack as seen one edge earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_d <= 1'b0;
        else        ack_d <= hold_ack;
    end

    // Admission: grant stable for a cycle, controller idle, pipe empty.
    assign accept = !snp_strobe_n && hold_ack && ack_d && seq_idle && !s1_v && !res_v;

    // Stage 1 capture of the accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_addr <= '0;
            s1_inv  <= 1'b0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_addr <= snp_addr;
                s1_inv  <= snp_inv;
            end
        end
    end

    assign rd_idx = s1_addr[OFF_W +: IDX_W];
    assign s1_tag = s1_addr[ADDR_W-1 -: TAG_W];

    // Tag compare on the stage 1 address.
    assign look_hit = s1_v && (rd_state != LS_INV) && (rd_tag == s1_tag);

    // State update from the invalidate flag on any hit.
    always_comb begin
        upd_en    = look_hit;
        upd_idx   = rd_idx;
        upd_state = s1_inv ? LS_INV : LS_SHR;
    end

    // Stage 2 result register handed to the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_v    <= 1'b0;
            res_mod  <= 1'b0;
            res_hit  <= 1'b0;
            res_line <= '0;
        end else begin
            res_v    <= s1_v;
            res_mod  <= look_hit && (rd_state == LS_MOD);
            res_hit  <= look_hit;
            res_line <= s1_addr[ADDR_W-1:OFF_W];
        end
    end

    // Presence flag, published alongside hitm_n.
    always_ff @(posedge clk) begin
        if (!rst_n)     snoop_hit <= 1'b0;
        else if (res_v) snoop_hit <= res_hit;
    end

    // R2: the lookup stage is only ever loaded by an admitted strobe.
    p_stage_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s1_v) |-> $past(hold_ack) && $past(ack_d));

endmodule

// File: rtl/snp_wb_ctrl.sv
// Hold handshake and write-back burst controller.
// Assumes res_v/res_mod arrive only while idle. Drops the grant once hold is
// released after a dirty hit, bursts the line, and re-grants after completion.
module snp_wb_ctrl
    import snp_wb_pkg::*;
#(
    parameter int LINE_W     = 12,
    parameter int BEAT_W     = 2,
    parameter int GAP_CYCLES = 1,
    parameter int GAP_W      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req,
    input  logic              res_v,
    input  logic              res_mod,
    input  logic [LINE_W-1:0] res_line,
    input  logic              rdy_n,
    input  logic              last_n,
    output logic              hold_ack,
    output logic              hitm_n,
    output logic              ads_n,
    output logic              burst_n,
    output logic              bus_write,
    output logic [LINE_W-1:0] wb_line,
    output logic [BEAT_W-1:0] wb_beat,
    output logic              seq_idle
);

    seq_st_t          st_q;
    seq_st_t          st_d;
    logic [GAP_W-1:0] gap_q;
    logic             dirty_in;
    logic             rel_seen;
    logic             gap_out;
    logic             beat_rdy;
    logic             burst_end;

    assign dirty_in  = res_v && res_mod;
    assign rel_seen  = (st_q == SQ_HIT) && !hold_req;
    assign gap_out   = (st_q == SQ_GAP) && (gap_q == '0);
    assign beat_rdy  = (st_q == SQ_DATA) && !rdy_n;
    assign burst_end = beat_rdy && !last_n;

    // Next-state selection for the handshake sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            SQ_IDLE: if (dirty_in)  st_d = SQ_HIT;
            SQ_HIT:  if (rel_seen)  st_d = SQ_GAP;
            SQ_GAP:  if (gap_out)   st_d = SQ_ADDR;
            SQ_ADDR:                st_d = SQ_DATA;
            SQ_DATA: if (burst_end) st_d = SQ_DONE;
            SQ_DONE:                st_d = SQ_IDLE;
            default:                st_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    // Grant register: follows hold_req only when the bus is not ours.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_ack <= 1'b0;
        else if (st_q == SQ_IDLE || st_q == SQ_HIT)
            hold_ack <= hold_req;
        else
            hold_ack <= 1'b0;
    end

    // Hit-modified flag: set on a dirty result, cleared on the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hitm_n <= 1'b1;
        else if (st_q == SQ_IDLE && dirty_in) hitm_n <= 1'b0;
        else if (burst_end)                  hitm_n <= 1'b1;
    end

    // Line address latched for the burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                          wb_line <= '0;
        else if (st_q == SQ_IDLE && dirty_in) wb_line <= res_line;
    end

    // Gap counter between hold release and the address strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          gap_q <= '0;
        else if (rel_seen)   gap_q <= GAP_W'(GAP_CYCLES - 1);
        else if (st_q == SQ_GAP && !gap_out) gap_q <= gap_q - 1'b1;
    end

    // Beat counter: cleared on hold release, stepped by non-final readies.
    always_ff @(posedge clk) begin
        if (!rst_n)                   wb_beat <= '0;
        else if (rel_seen)            wb_beat <= '0;
        else if (beat_rdy && last_n)  wb_beat <= wb_beat + 1'b1;
    end

    // Bus control decode from the registered state.
    always_comb begin
        ads_n     = (st_q != SQ_ADDR);
        burst_n   = (st_q != SQ_ADDR);
        bus_write = (st_q == SQ_ADDR) || (st_q == SQ_DATA);
        seq_idle  = (st_q == SQ_IDLE);
    end

    // R5: the grant is never up while this block drives the bus.
    p_no_ack_on_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n || st_q == SQ_DATA) |-> !hold_ack);

    // R6: the address strobe always carries burst and write qualifiers.
    p_strobe_quals_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> (!burst_n && bus_write));

    // R6: the strobe starts only after the grant was already down.
    p_strobe_after_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ads_n) |-> !$past(hold_ack));

    // R7: without a ready the beat index holds inside the data phase.
    p_beat_needs_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_DATA && $past(st_q == SQ_DATA) && $past(rdy_n)) |-> $stable(wb_beat));

    // R9: the grant is raised only in answer to a sampled hold request.
    p_ack_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_req));

endmodule

// File: rtl/snp_wb_seq.sv
// Snoop hit write-back sequencer top: joins the tag store, the snoop
// lookup pipeline and the hold/write-back controller. Assumes a single
// clock and that fills come from the processor's own miss path.
module snp_wb_seq
    import snp_wb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 4,
    parameter int SETS       = 8,
    parameter int BEATS      = 4,
    parameter int GAP_CYCLES = 1,
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int GAP_W     = $clog2(GAP_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req,
    output logic              hold_ack,
    input  logic              snp_strobe_n,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_inv,
    output logic              hitm_n,
    output logic              snoop_hit,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    output logic              ads_n,
    output logic              burst_n,
    output logic              bus_write,
    output logic [LINE_W-1:0] wb_line,
    output logic [BEAT_W-1:0] wb_beat,
    input  logic              rdy_n,
    input  logic              last_n
);

    logic [IDX_W-1:0]  rd_idx;
    logic [TAG_W-1:0]  rd_tag;
    line_st_t          rd_state;
    logic              upd_en;
    logic [IDX_W-1:0]  upd_idx;
    line_st_t          upd_state;
    line_st_t          fill_state;
    logic              accept;
    logic              res_v;
    logic              res_mod;
    logic [LINE_W-1:0] res_line;
    logic              seq_idle;

    assign fill_state = fill_dirty ? LS_MOD : LS_EXC;

    snp_tag_store #(
        .SETS  (SETS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_idx),
        .rd_tag     (rd_tag),
        .rd_state   (rd_state),
        .upd_en     (upd_en),
        .upd_idx    (upd_idx),
        .upd_state  (upd_state),
        .fill_en    (fill_en),
        .fill_idx   (fill_addr[OFF_W +: IDX_W]),
        .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
        .fill_state (fill_state)
    );

    snp_lookup #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_look (
        .clk          (clk),
        .rst_n        (rst_n),
        .snp_strobe_n (snp_strobe_n),
        .snp_addr     (snp_addr),
        .snp_inv      (snp_inv),
        .hold_ack     (hold_ack),
        .seq_idle     (seq_idle),
        .rd_idx       (rd_idx),
        .rd_tag       (rd_tag),
        .rd_state     (rd_state),
        .accept       (accept),
        .upd_en       (upd_en),
        .upd_idx      (upd_idx),
        .upd_state    (upd_state),
        .res_v        (res_v),
        .res_mod      (res_mod),
        .res_line     (res_line),
        .snoop_hit    (snoop_hit)
    );

    snp_wb_ctrl #(
        .LINE_W     (LINE_W),
        .BEAT_W     (BEAT_W),
        .GAP_CYCLES (GAP_CYCLES),
        .GAP_W      (GAP_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .res_v     (res_v),
        .res_mod   (res_mod),
        .res_line  (res_line),
        .rdy_n     (rdy_n),
        .last_n    (last_n),
        .hold_ack  (hold_ack),
        .hitm_n    (hitm_n),
        .ads_n     (ads_n),
        .burst_n   (burst_n),
        .bus_write (bus_write),
        .wb_line   (wb_line),
        .wb_beat   (wb_beat),
        .seq_idle  (seq_idle)
    );

    // R2: admission needs the grant up now and at the previous edge.
    p_accept_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (hold_ack && $past(hold_ack)));

    // R3: hitm_n falls exactly three edges after the admitting edge.
    p_hitm_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hitm_n) |-> $past(accept, 3));

    // R8: hitm_n releases only after a final-beat ready.
    p_hitm_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hitm_n) |-> $past(!rdy_n && !last_n));

    // R10: no strobe is admitted while a dirty hit is outstanding.
    p_no_snoop_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hitm_n |-> !accept);

endmodule

// File: tb/sim_snp_wb_seq.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenario checks tagged with the requirement they exercise.
module sim_snp_wb_seq;

    localparam int ADDR_W = 16;
    localparam int OFF_W  = 4;
    localparam int SETS   = 8;
    localparam int IDX_W  = 3;
    localparam int GAP    = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hold_req = 1'b0;
    logic              hold_ack;
    logic              snp_strobe_n = 1'b1;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_inv = 1'b0;
    logic              hitm_n;
    logic              snoop_hit;
    logic              fill_en = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic              fill_dirty = 1'b0;
    logic              ads_n;
    logic              burst_n;
    logic              bus_write;
    logic [11:0]       wb_line;
    logic [1:0]        wb_beat;
    logic              rdy_n = 1'b1;
    logic              last_n = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit model_live = 0;

    always #2.5 clk = ~clk;

    snp_wb_seq u0 (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
        .snp_strobe_n(snp_strobe_n), .snp_addr(snp_addr), .snp_inv(snp_inv),
        .hitm_n(hitm_n), .snoop_hit(snoop_hit), .fill_en(fill_en),
        .fill_addr(fill_addr), .fill_dirty(fill_dirty), .ads_n(ads_n),
        .burst_n(burst_n), .bus_write(bus_write), .wb_line(wb_line),
        .wb_beat(wb_beat), .rdy_n(rdy_n), .last_n(last_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    // Line states: 0 invalid, 1 shared, 2 exclusive, 3 modified.
    // Phases: 0 idle, 1 dirty hit, 2 gap, 3 address, 4 data, 5 done.
    int m_tag [SETS];
    int m_ls  [SETS];
    int m_ack, m_ackd, m_ph, m_gap, m_beat, m_hitm, m_hit, m_line;
    int q_addr [$];
    int q_inv  [$];
    int q_age  [$];
    int r_v, r_mod, r_hit, r_line;

    always @(posedge clk) begin
        int old_ack, idx, tg, fidx, hit, mod, acc, a;
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin m_tag[i] = 0; m_ls[i] = 0; end
            m_ack = 0; m_ackd = 0; m_ph = 0; m_gap = 0; m_beat = 0;
            m_hitm = 1; m_hit = 0; m_line = 0;
            q_addr.delete(); q_inv.delete(); q_age.delete();
            r_v = 0; r_mod = 0; r_hit = 0; r_line = 0;
            model_live = 1;
        end else begin
            old_ack = m_ack;
            acc = (snp_strobe_n == 0) && m_ack && m_ackd && (m_ph == 0)
                  && (q_addr.size() == 0) && !r_v;
            if (r_v) m_hit = r_hit;
            case (m_ph)
                0: begin
                    m_ack = hold_req;
                    if (r_v && r_mod) begin m_ph = 1; m_hitm = 0; m_line = r_line; end
                end
                1: if (!hold_req) begin m_ack = 0; m_ph = 2; m_gap = GAP - 1; m_beat = 0; end
                   else m_ack = 1;
                2: if (m_gap == 0) m_ph = 3; else m_gap--;
                3: m_ph = 4;
                4: if (!rdy_n) begin
                       if (!last_n) begin m_ph = 5; m_hitm = 1; end
                       else m_beat = (m_beat + 1) % 4;
                   end
                default: m_ph = 0;
            endcase
            r_v = 0; r_mod = 0; r_hit = 0; hit = 0; idx = -1;
            if (q_addr.size() != 0) begin
                a   = q_addr.pop_front();
                idx = (a >> OFF_W) % SETS;
                tg  = a >> (OFF_W + IDX_W);
                hit = (m_ls[idx] != 0) && (m_tag[idx] == tg);
                mod = hit && (m_ls[idx] == 3);
                if (hit) m_ls[idx] = q_inv.pop_front() ? 0 : 1;
                else void'(q_inv.pop_front());
                void'(q_age.pop_front());
                r_v = 1; r_hit = hit; r_mod = mod; r_line = a >> OFF_W;
            end
            if (fill_en) begin
                fidx = (int'(fill_addr) >> OFF_W) % SETS;
                if (!(hit && fidx == idx)) begin
                    m_tag[fidx] = int'(fill_addr) >> (OFF_W + IDX_W);
                    m_ls[fidx]  = fill_dirty ? 3 : 2;
                end
            end
            if (acc) begin
                q_addr.push_back(int'(snp_addr));
                q_inv.push_back(int'(snp_inv));
                q_age.push_back(0);
            end
            m_ackd = old_ack;
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && model_live) begin
            chk("R5", "hold_ack vs model", int'(hold_ack), m_ack);
            chk("R3", "hitm_n vs model", int'(hitm_n), m_hitm);
            chk("R4", "snoop_hit vs model", int'(snoop_hit), m_hit);
            chk("R6", "ads_n vs model", int'(ads_n), (m_ph == 3) ? 0 : 1);
            chk("R6", "burst_n vs model", int'(burst_n), (m_ph == 3) ? 0 : 1);
            chk("R6", "bus_write vs model", int'(bus_write), (m_ph == 3 || m_ph == 4) ? 1 : 0);
            if (m_ph == 3) chk("R6", "wb_line vs model", int'(wb_line), m_line);
            if (m_ph == 4) chk("R7", "wb_beat vs model", int'(wb_beat), m_beat);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic fill(input logic [ADDR_W-1:0] a, input logic dirty);
        @(negedge clk); fill_en = 1'b1; fill_addr = a; fill_dirty = dirty;
        @(negedge clk); fill_en = 1'b0;
    endtask

    // Strobe for one edge; returns at the negedge after the sampling edge.
    task automatic snoop(input logic [ADDR_W-1:0] a, input logic inv);
        @(negedge clk); snp_strobe_n = 1'b0; snp_addr = a; snp_inv = inv;
        @(negedge clk); snp_strobe_n = 1'b1;
    endtask

    // Snoop and read the result two edges later.
    task automatic probe(input logic [ADDR_W-1:0] a, input logic inv,
                         input string req, input int exp_hit, input int exp_hitm);
        snoop(a, inv);
        @(negedge clk);
        @(negedge clk);
        chk(req, "snoop_hit", int'(snoop_hit), exp_hit);
        chk(req, "hitm_n", int'(hitm_n), exp_hitm);
    endtask

    localparam logic [ADDR_W-1:0] LA = 16'h1230;
    localparam logic [ADDR_W-1:0] LB = 16'h0450;
    localparam logic [ADDR_W-1:0] LC = 16'h0760;
    localparam logic [ADDR_W-1:0] LD = 16'h2230;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "hold_ack in reset", int'(hold_ack), 0);
        chk("R1", "hitm_n in reset", int'(hitm_n), 1);
        chk("R1", "snoop_hit in reset", int'(snoop_hit), 0);
        chk("R1", "ads_n in reset", int'(ads_n), 1);
        chk("R1", "bus_write in reset", int'(bus_write), 0);
        rst_n = 1'b1;

        fill(LA, 1'b1);
        fill(LB, 1'b0);
        fill(LC, 1'b1);

        hold_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5", "grant follows request", int'(hold_ack), 1);

        // Miss and clean hits leave the grant alone.
        probe(LD, 1'b0, "R11", 0, 1);
        chk("R11", "grant kept on miss", int'(hold_ack), 1);
        probe(LB, 1'b0, "R12", 1, 1);
        chk("R11", "grant kept on clean hit", int'(hold_ack), 1);
        probe(LB, 1'b1, "R4", 1, 1);
        probe(LB, 1'b0, "R4", 0, 1);

        // Strobe one cycle after the grant rises is ignored.
        @(negedge clk); hold_req = 1'b0;
        repeat (2) @(negedge clk);
        hold_req = 1'b1;
        @(negedge clk);
        chk("R2", "grant just raised", int'(hold_ack), 1);
        snp_strobe_n = 1'b0; snp_addr = LA; snp_inv = 1'b1;
        @(negedge clk); snp_strobe_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2", "early strobe leaves hitm_n", int'(hitm_n), 1);

        // Dirty hit: hitm_n timing.
        snoop(LA, 1'b1);
        @(negedge clk);
        chk("R3", "hitm_n one edge after", int'(hitm_n), 1);
        @(negedge clk);
        chk("R3", "hitm_n two edges after", int'(hitm_n), 0);

        // Snoop of another dirty line while pending is ignored.
        snoop(LC, 1'b1);
        repeat (2) @(negedge clk);
        chk("R5", "grant held while hold requested", int'(hold_ack), 1);

        // Release hold; write-back starts one clock later.
        hold_req = 1'b0;
        @(negedge clk);
        chk("R5", "grant dropped", int'(hold_ack), 0);
        chk("R6", "no strobe yet", int'(ads_n), 1);
        @(negedge clk);
        chk("R6", "address strobe", int'(ads_n), 0);
        chk("R6", "burst indicator", int'(burst_n), 0);
        chk("R6", "write cycle", int'(bus_write), 1);
        chk("R6", "write-back line", int'(wb_line), int'(LA >> OFF_W));
        rdy_n = 1'b0;
        hold_req = 1'b1;
        @(negedge clk);
        chk("R7", "ready in address cycle ignored", int'(wb_beat), 0);
        rdy_n = 1'b1;
        @(negedge clk);
        chk("R7", "wait state holds beat", int'(wb_beat), 0);
        chk("R5", "grant stays down in burst", int'(hold_ack), 0);
        rdy_n = 1'b0;
        @(negedge clk);
        chk("R7", "beat 1", int'(wb_beat), 1);
        @(negedge clk);
        chk("R7", "beat 2", int'(wb_beat), 2);
        @(negedge clk);
        chk("R7", "beat 3", int'(wb_beat), 3);
        chk("R8", "hitm_n low before last", int'(hitm_n), 0);
        last_n = 1'b0;
        @(negedge clk);
        rdy_n = 1'b1; last_n = 1'b1;
        chk("R8", "hitm_n released", int'(hitm_n), 1);
        chk("R8", "bus released", int'(bus_write), 0);
        chk("R9", "grant low after completion", int'(hold_ack), 0);
        @(negedge clk);
        chk("R9", "grant low one more clock", int'(hold_ack), 0);
        @(negedge clk);
        chk("R9", "grant re-raised", int'(hold_ack), 1);

        // LC stayed dirty because its snoop was ignored.
        probe(LC, 1'b0, "R10", 1, 0);

        // Second write-back without wait states.
        hold_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R6", "second line address", int'(wb_line), int'(LC >> OFF_W));
        rdy_n = 1'b1;
        @(negedge clk);
        rdy_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "second burst beat 3", int'(wb_beat), 3);
        last_n = 1'b0;
        @(negedge clk);
        rdy_n = 1'b1; last_n = 1'b1;
        chk("R8", "second hitm_n release", int'(hitm_n), 1);
        repeat (2) @(negedge clk);
        chk("R9", "no grant without request", int'(hold_ack), 0);
        hold_req = 1'b1;
        repeat (3) @(negedge clk);

        probe(LA, 1'b0, "R4", 0, 1);
        probe(LC, 1'b0, "R4", 1, 1);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule